// File: doc/BRIEF.md
# I2C Sequencing Master

This block is an I2C bus master that software drives through eight byte-wide registers. Software sets a clock rate, a transaction kind, a channel number, a target address with its direction bit and, when needed, a one-byte subaddress. A single control write then starts the transfer. The block produces the START condition, the address byte, any subaddress byte and any repeated START on its own. It then stops with SCL held low and waits for software at each byte boundary.

After the address phase, software moves the transfer along through the same registers. On a write, writing the data register sends a byte. On a read, writing 1 to clear the address-done flag or the data-done flag fetches the next byte. Setting the STOP bit ends a write. A read ends by itself once a byte has been given a NAK. Four event flags record what has happened. Each flag is cleared by writing 1 to it, and any flag that is enabled raises the interrupt line. Both bus lines are open-drain outputs: the block only pulls them low.

Top module: `i2c_seq_master`

## Requirements
- R1: The register at index i sits at byte address i << STEP (default stride 16). The indices are: 0 mode, 1 control, 2 status, 3 event flags, 4 event enable, 5 address, 6 subaddress, 7 data. The mode, enable, address and subaddress registers read back the value written. chan_sel shows mode bits [7:4].
- R2: After reset all registers are zero, neither bus line is pulled, irq is low, and status reads live SCL in bit 4 and live SDA in bit 3 (0x18 on an idle bus).
- R3: Mode bits [1:0] select the SCL period. A value of 0 gives 100 kHz, 1 gives 50 kHz, and 2 or 3 gives 25 kHz. One SCL period is 4 × CLK_HZ/(4 × rate) system clocks.
- R4: With mode bits [3:2] = 1 (plain), writing control bit 1 sends START and then the address byte, MSB first. When the ninth clock ends, event flag bit 3 (START done) and flag bit 1 (address done) are set. Status then shows busy in bit 0, the target's ACK in bit 1 and the direction in bit 2, with SCL held low.
- R5: With mode bits [3:2] = 2, the address byte is followed by the subaddress byte, and only then does the address-done flag rise.
- R6: With mode bits [3:2] = 3, the block sends START, the address with bit 0 forced to 0, the subaddress, a repeated START, and then the address as programmed. After that it sets the address-done flag.
- R7: If any address-phase byte gets a NAK, the address-done flag rises at once with status bit 1 = 0, and the rest of the address phase is skipped.
- R8: In write direction, writing the data register while the block is waiting sends that byte. When it finishes, the data-done flag (bit 0) is set and status bit 1 holds the target's ACK.
- R9: In read direction, writing 1 to flag bit 0 or bit 1 while the block is waiting receives one byte into the data register. The byte is given an ACK when control bit 0 is 1 and a NAK otherwise. After a NAK the block sends STOP on its own.
- R10: Writing control bit 2 while the block is waiting sends STOP. Busy stays 1 until the STOP condition completes, then falls in the same cycle that flag bit 2 (STOP done) rises.
- R11: Writing 1 to a flag bit clears it. irq is high exactly when some flag is set and its enable bit is 1.
- R12: With mode bits [3:2] = 0, the start request in control bit 1 is ignored: busy stays 0, no flag rises and the bus stays idle.
- R13: While SCL is released, SDA changes only as part of a START or STOP condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | STEP+3 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| chan_sel | output | 4 | Selected bus channel |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |

## Verification
A register write takes effect on the clock edge that captures it. Register contents, status and irq can therefore be read at the falling edge that ends the write, and the bench checks them there. Bus-level results follow the quarter-period counter: a byte takes 36 quarters and a START or STOP takes 4. An event flag rises on the clock that ends the last quarter. For that reason the bench polls the flag register instead of counting cycles, and it checks the bus-event order through a scoreboard fed by a bench-side target model. It measures the SCL period in system clocks between two consecutive rising edges of address bits.

// File: rtl/i2c_seq_master.sv
module i2c_seq_master #(
  parameter int CLK_HZ = 100_000_000,
  parameter int STEP   = 4,
  localparam int AW    = STEP + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic [3:0]    chan_sel,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_pull,
  output logic          sda_pull
);
  localparam int Q100 = CLK_HZ / 400_000;
  localparam int Q50  = CLK_HZ / 200_000;
  localparam int Q25  = CLK_HZ / 100_000;
  localparam int QW   = $clog2(Q25 + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR1, S_SUB, S_RSTART, S_ADDR2, S_WAIT, S_DATA, S_STOP
  } st_t;

  st_t         st;
  logic [7:0]  mode_r, addr_r, sub_r, data_r, sh;
  logic        aak_r, dir_r, ack_r, smp;
  logic [3:0]  isr_r, ier_r, ev;
  logic [QW-1:0] qcnt, qlen;
  logic [1:0]  q;
  logic [3:0]  bitn;

  wire hit     = (reg_addr & AW'((1 << STEP) - 1)) == '0;
  wire [2:0] idx = reg_addr[AW-1:STEP];
  wire wr_ok   = reg_wr && hit;
  wire wr_mode = wr_ok && idx == 3'd0;
  wire wr_ctrl = wr_ok && idx == 3'd1;
  wire wr_isr  = wr_ok && idx == 3'd3;
  wire wr_ier  = wr_ok && idx == 3'd4;
  wire wr_addr = wr_ok && idx == 3'd5;
  wire wr_sub  = wr_ok && idx == 3'd6;
  wire wr_data = wr_ok && idx == 3'd7;

  wire [1:0] kind   = mode_r[3:2];
  wire busy         = st != S_IDLE;
  wire running      = busy && st != S_WAIT;
  wire tick         = running && qcnt == '0;
  wire last_q       = tick && q == 2'd3;
  wire byte_st      = st == S_ADDR1 || st == S_SUB || st == S_ADDR2 || st == S_DATA;
  wire cond_st      = st == S_START || st == S_RSTART || st == S_STOP;
  wire rx_byte      = st == S_DATA && dir_r;
  wire byte_end     = last_q && byte_st && bitn == 4'd8;
  wire ack_in       = !smp;
  wire [3:0] clr    = wr_isr ? reg_wdata[3:0] : 4'h0;

  assign irq      = |(isr_r & ier_r);
  assign chan_sel = mode_r[7:4];

  always_comb begin
    case (mode_r[1:0])
      2'd0:    qlen = QW'(Q100);
      2'd1:    qlen = QW'(Q50);
      default: qlen = QW'(Q25);
    endcase
  end

  always_comb begin
    case (idx)
      3'd0: reg_rdata = mode_r;
      3'd1: reg_rdata = {7'b0, aak_r};
      3'd2: reg_rdata = {3'b0, scl_in, sda_in, dir_r, ack_r, busy};
      3'd3: reg_rdata = {4'b0, isr_r};
      3'd4: reg_rdata = {4'b0, ier_r};
      3'd5: reg_rdata = addr_r;
      3'd6: reg_rdata = sub_r;
      default: reg_rdata = data_r;
    endcase
    if (!hit) reg_rdata = 8'h00;
  end

  always_comb begin
    ev = 4'h0;
    if (last_q && (st == S_START || st == S_RSTART)) ev[3] = 1'b1;
    if (last_q && st == S_STOP) ev[2] = 1'b1;
    if (byte_end) begin
      if (st == S_DATA) ev[0] = 1'b1;
      else if (st == S_ADDR2 || !ack_in || kind == 2'd1 || (st == S_SUB && kind == 2'd2))
        ev[1] = 1'b1;
    end
  end

  always_comb begin
    scl_pull = 1'b0;
    sda_pull = 1'b0;
    case (st)
      S_START, S_RSTART: begin
        scl_pull = (q == 2'd0) ? (st == S_RSTART) : (q == 2'd3);
        sda_pull = q[1];
      end
      S_STOP: begin
        scl_pull = q == 2'd0;
        sda_pull = q != 2'd3;
      end
      S_WAIT: scl_pull = 1'b1;
      S_ADDR1, S_SUB, S_ADDR2, S_DATA: begin
        scl_pull = q == 2'd0 || q == 2'd3;
        sda_pull = (bitn < 4'd8) ? (!rx_byte && !sh[7]) : (rx_byte && aak_r);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mode_r <= '0; addr_r <= '0; sub_r <= '0; data_r <= '0; sh <= '0;
      aak_r <= 1'b0; dir_r <= 1'b0; ack_r <= 1'b0; smp <= 1'b0;
      isr_r <= '0; ier_r <= '0; qcnt <= '0; q <= '0; bitn <= '0;
    end else begin
      if (wr_mode) mode_r <= reg_wdata;
      if (wr_ctrl) aak_r  <= reg_wdata[0];
      if (wr_ier)  ier_r  <= reg_wdata[3:0];
      if (wr_addr) addr_r <= reg_wdata;
      if (wr_sub)  sub_r  <= reg_wdata;
      if (wr_data) data_r <= reg_wdata;
      isr_r <= (isr_r & ~clr) | ev;

      if (!running) begin
        qcnt <= qlen - 1'b1;
        q    <= '0;
        bitn <= '0;
      end else if (tick) begin
        qcnt <= qlen - 1'b1;
        q    <= q + 2'd1;
        if (q == 2'd1) smp <= sda_in;
        if (q == 2'd3 && byte_st) begin
          if (bitn == 4'd8) bitn <= '0;
          else begin
            bitn <= bitn + 4'd1;
            sh   <= {sh[6:0], smp};
          end
        end
      end else begin
        qcnt <= qcnt - 1'b1;
      end

      case (st)
        S_IDLE:
          if (wr_ctrl && reg_wdata[1] && kind != 2'd0) begin
            st    <= S_START;
            dir_r <= addr_r[0];
          end
        S_START:
          if (last_q) begin
            st <= S_ADDR1;
            sh <= (kind == 2'd3) ? {addr_r[7:1], 1'b0} : addr_r;
          end
        S_ADDR1, S_SUB, S_ADDR2:
          if (byte_end) begin
            ack_r <= ack_in;
            if (ev[1]) st <= S_WAIT;
            else if (st == S_ADDR1) begin
              st <= S_SUB;
              sh <= sub_r;
            end else st <= S_RSTART;
          end
        S_RSTART:
          if (last_q) begin
            st <= S_ADDR2;
            sh <= addr_r;
          end
        S_WAIT:
          if (wr_ctrl && reg_wdata[2]) st <= S_STOP;
          else if (wr_data && !dir_r) begin
            st <= S_DATA;
            sh <= reg_wdata;
          end else if (wr_isr && |reg_wdata[1:0] && dir_r && ack_r) begin
            st <= S_DATA;
            sh <= 8'hFF;
          end
        S_DATA:
          if (byte_end) begin
            if (dir_r) begin
              data_r <= sh;
              st     <= aak_r ? S_WAIT : S_STOP;
            end else begin
              ack_r <= ack_in;
              st    <= S_WAIT;
            end
          end
        S_STOP:
          if (last_q) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull && !$past(scl_pull) && !cond_st && !$past(cond_st)) |-> $stable(sda_pull)); // R13
  AST_BUSY_ENDS_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(st) == S_STOP && isr_r[2])); // R10
  AST_RAW_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && kind == 2'd0) |=> st == S_IDLE); // R12
  AST_NAK_SKIPS_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SUB && $past(st) == S_ADDR1) |-> ack_r); // R7
  AST_RX_NAK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_DATA && st == S_STOP) |-> ($past(dir_r) && !$past(aak_r))); // R9
endmodule

// File: tb/i2c_seq_master_test.sv
module i2c_seq_master_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_HZ = 4_000_000;
  localparam int STEP   = 4;
  localparam int AW     = STEP + 3;
  localparam logic [6:0] TGT = 7'h50;
  localparam logic [11:0] EV_S = 12'h100;
  localparam logic [11:0] EV_P = 12'h200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  wire  [7:0]    reg_rdata;
  wire           irq;
  wire  [3:0]    chan_sel;
  wire           scl_pull, sda_pull;
  logic          tgt_low = 1'b0;
  wire           scl_ln = !scl_pull;
  wire           sda_ln = !(sda_pull || tgt_low);

  i2c_seq_master #(.CLK_HZ(CLK_HZ), .STEP(STEP)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .chan_sel(chan_sel),
    .scl_in(scl_ln), .sda_in(sda_ln), .scl_pull(scl_pull), .sda_pull(sda_pull));

  int vectors = 0;
  int errors  = 0;
  logic [11:0] expq[$];
  string       reqq[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_ev(logic [11:0] code, string req);
    expq.push_back(code);
    reqq.push_back(req);
  endtask

  function automatic logic [11:0] byte_ev(logic nak, logic [7:0] b);
    return {3'b100, nak, b};
  endfunction

  task automatic observe(logic [11:0] code);
    if (expq.size() == 0) begin
      vectors++;
      errors++;
      $display("FAIL R13: unexpected bus event actual %0h expected none", code);
    end else begin
      logic [11:0] e;
      string r;
      e = expq.pop_front();
      r = reqq.pop_front();
      check(r, code, e);
    end
  endtask

  // bench-side target and bus monitor
  int bc = 0;
  logic [7:0] msh = '0, txb = '0, tx_next = 8'hC3;
  logic first = 1'b0, rd = 1'b0, tx_on = 1'b0, ackb = 1'b0;

  always @(negedge sda_ln) if (rst_n && scl_ln) begin
    bc = 0; first = 1'b1; rd = 1'b0; tx_on = 1'b0; tgt_low = 1'b0;
    observe(EV_S);
  end

  always @(posedge sda_ln) if (rst_n && scl_ln) begin
    tx_on = 1'b0; tgt_low = 1'b0;
    observe(EV_P);
  end

  always @(posedge scl_ln) if (rst_n) begin
    if (bc < 8) msh = {msh[6:0], sda_ln};
    else ackb = sda_ln;
    bc++;
    if (bc == 9) observe(byte_ev(ackb, msh));
  end

  always @(negedge scl_ln) if (rst_n) begin
    if (bc == 8) begin
      tgt_low = first ? (msh[7:1] == TGT) : !rd;
    end else if (bc == 9) begin
      bc = 0;
      tgt_low = 1'b0;
      if (first) begin
        first = 1'b0;
        rd = (msh[7:1] == TGT) && msh[0];
      end
      tx_on = rd && !ackb;
      if (tx_on) begin
        txb = tx_next;
        tx_next = tx_next + 8'd1;
        tgt_low = !txb[7];
      end
    end else if (bc >= 1 && bc <= 7 && tx_on) begin
      tgt_low = !txb[7-bc];
    end
  end

  task automatic wr(int i, logic [7:0] d);
    @(negedge clk);
    reg_addr = AW'(i << STEP);
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(int i, output logic [7:0] v);
    @(negedge clk);
    reg_addr = AW'(i << STEP);
    #1 v = reg_rdata;
  endtask

  task automatic wait_flag(int b);
    logic [7:0] v;
    v = '0;
    while (!v[b]) rd_reg(3, v);
  endtask

  task automatic measure(int qlen, string req);
    time t0, t1;
    @(posedge scl_ln); t0 = $time;
    @(posedge scl_ln); t1 = $time;
    check(req, 32'((t1 - t0) / 4), 32'(4 * qlen));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    rd_reg(2, v); check("R2 status", v, 8'h18);
    rd_reg(3, v); check("R2 flags", v, 8'h00);
    check("R2 irq", irq, 1'b0);
    check("R2 lines", {scl_pull, sda_pull}, 2'b00);

    wr(0, 8'h35); rd_reg(0, v); check("R1 mode", v, 8'h35);
    check("R1 chan_sel", chan_sel, 4'h3);
    wr(5, 8'hA0); rd_reg(5, v); check("R1 address", v, 8'hA0);
    wr(6, 8'h12); rd_reg(6, v); check("R1 subaddress", v, 8'h12);
    wr(4, 8'h0B); rd_reg(4, v); check("R1 enable", v, 8'h0B);
    wr(4, 8'h00);

    // plain write at 100 kHz
    wr(0, 8'h04);
    expect_ev(EV_S, "R4");
    expect_ev(byte_ev(1'b0, 8'hA0), "R4");
    wr(1, 8'h02);
    measure(10, "R3 100k");
    wait_flag(1);
    rd_reg(2, v); check("R4 status", v, 8'h0B);
    rd_reg(3, v); check("R4 flags", v, 8'h0A);
    check("R11 irq masked", irq, 1'b0);
    wr(4, 8'h02); check("R11 irq enabled", irq, 1'b1);
    wr(3, 8'h0A); rd_reg(3, v); check("R11 clear", v, 8'h00);
    check("R11 irq after clear", irq, 1'b0);
    expect_ev(byte_ev(1'b0, 8'h5C), "R8");
    wr(7, 8'h5C);
    wait_flag(0);
    rd_reg(2, v); check("R8 ack", v[1:0], 2'b11);
    expect_ev(EV_P, "R10");
    wr(3, 8'h01);
    wr(1, 8'h04);
    rd_reg(2, v); check("R10 busy during stop", v[0], 1'b1);
    wait_flag(2);
    rd_reg(2, v); check("R10 idle status", v, 8'h1A);
    rd_reg(3, v); check("R10 stop flag", v, 8'h04);
    wr(3, 8'h0F); wr(4, 8'h00);

    // NAK on address with subaddress mode
    wr(0, 8'h08); wr(5, 8'h42); wr(6, 8'h99);
    expect_ev(EV_S, "R7");
    expect_ev(byte_ev(1'b1, 8'h42), "R7");
    wr(1, 8'h02);
    wait_flag(1);
    rd_reg(2, v); check("R7 nak status", v[1:0], 2'b01);
    expect_ev(EV_P, "R7");
    wr(3, 8'h0F); wr(1, 8'h04);
    wait_flag(2); wr(3, 8'h0F);

    // subaddress write at 50 kHz
    wr(0, 8'h09); wr(5, 8'hA0); wr(6, 8'h33);
    expect_ev(EV_S, "R5");
    expect_ev(byte_ev(1'b0, 8'hA0), "R5");
    expect_ev(byte_ev(1'b0, 8'h33), "R5");
    wr(1, 8'h02);
    measure(20, "R3 50k");
    wait_flag(1);
    rd_reg(2, v); check("R5 status", v, 8'h0B);
    expect_ev(byte_ev(1'b0, 8'h77), "R8");
    wr(3, 8'h0F); wr(7, 8'h77);
    wait_flag(0);
    expect_ev(EV_P, "R10");
    wr(1, 8'h04);
    wait_flag(2); wr(3, 8'h0F);

    // combined read at 25 kHz
    wr(0, 8'h0E); wr(5, 8'hA1); wr(6, 8'h44);
    expect_ev(EV_S, "R6");
    expect_ev(byte_ev(1'b0, 8'hA0), "R6");
    expect_ev(byte_ev(1'b0, 8'h44), "R6");
    expect_ev(EV_S, "R6");
    expect_ev(byte_ev(1'b0, 8'hA1), "R6");
    wr(1, 8'h02);
    measure(40, "R3 25k");
    wait_flag(1);
    rd_reg(2, v); check("R6 status", v, 8'h0F);
    wr(1, 8'h01);
    expect_ev(byte_ev(1'b0, 8'hC3), "R9");
    wr(3, 8'h0F);
    wait_flag(0);
    rd_reg(7, v); check("R9 first byte", v, 8'hC3);
    wr(1, 8'h00);
    expect_ev(byte_ev(1'b1, 8'hC4), "R9");
    expect_ev(EV_P, "R9");
    wr(3, 8'h01);
    wait_flag(2);
    rd_reg(7, v); check("R9 last byte", v, 8'hC4);
    rd_reg(2, v); check("R10 busy cleared", v[0], 1'b0);
    wr(3, 8'h0F);

    // raw mode ignores start
    wr(0, 8'h00); wr(1, 8'h02);
    repeat (50) @(negedge clk);
    rd_reg(2, v); check("R12 busy", v[0], 1'b0);
    check("R12 lines", {scl_pull, sda_pull}, 2'b00);
    rd_reg(3, v); check("R12 flags", v, 8'h00);

    repeat (20) @(negedge clk);
    check("R13 scoreboard drained", 32'(expq.size()), 32'd0);
    finish_run();
  end
endmodule